// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns three digitized supply comparisons into an ordered power-up sequence for the rest of the chip. The three comparisons are supply above the minimum valid level, supply above the upper threshold, and supply below the lower threshold. Once the supply clears the upper threshold, the block holds reset for a fixed number of master-clock cycles. It then releases the power-on reset into a start-up phase of fixed length. After that it enables the logic clock and asks an external calibration engine to run. When calibration reports completion, the block raises a monitors-ready flag.

A dip below the lower threshold counts as a brown-out only after it has lasted a minimum number of consecutive cycles. Shorter dips are rejected. A qualifying brown-out pulls the sequence back to the reset-wait phase, and the timing restarts only after the dip has ended. Loss of the valid-level indication drops everything straight back to the idle off state. All durations are parameters in master-clock cycles.

Top module: `por_sequencer`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `por_out`, `clk_en`, `cal_req` and `mon_ready` are all 0.
- R2: In the off phase, all outputs stay 0 until `supply_valid` and `above_high` are both 1 at a clock edge. That edge starts the reset-wait phase.
- R3: The reset-wait phase lasts exactly RESET_CYCLES edges while `above_high` stays 1, and all outputs are 0 during it. If `above_high` is 0 at an edge, the count restarts from that edge.
- R4: The start-up phase lasts STARTUP_CYCLES edges, with `por_out`=1 and `clk_en`=0. At the edge that ends it, `clk_en` and `cal_req` become 1.
- R5: `cal_req` stays 1 until `cal_done` is 1 at an edge. At that edge `cal_req` becomes 0 and `mon_ready` becomes 1, with `por_out` and `clk_en` still 1.
- R6: A run of `below_low`=1 shorter than BROWNOUT_CYCLES consecutive edges changes no output.
- R7: After `below_low` has been 1 for BROWNOUT_CYCLES consecutive edges, all four outputs become 0 at the next edge. The sequence then sits in reset-wait.
- R8: When `supply_valid` is 0 at an edge, all outputs are 0 after that edge, and the block returns to the off phase.
- R9: While a qualified brown-out persists, the block stays in reset-wait. The RESET_CYCLES count starts at the edge after the filter releases, so `por_out` rises RESET_CYCLES+1 edges after `below_low` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_valid | input | 1 | Supply is above the minimum valid level |
| above_high | input | 1 | Supply is above the upper threshold |
| below_low | input | 1 | Supply is below the lower (brown-out) threshold |
| cal_done | input | 1 | Calibration engine has finished |
| por_out | output | 1 | Internal power-on reset, high = released |
| clk_en | output | 1 | Logic clock enable |
| cal_req | output | 1 | Request to run analog calibration |
| mon_ready | output | 1 | Monitors ready after calibration |

## Verification
On every cycle, the embedded assertions check several ordering rules. Readiness implies a released reset and a running clock. Readiness rises only on a completion report. A qualified brown-out or loss of supply validity clears the outputs on the next edge, and the reset never falls for any other reason. The clock enable rises only after the reset has been released. The dip filter fires only after a low-side indication. The exact phase lengths, the restart of the reset-wait count when the upper threshold drops, and the rejection of dips one cycle shorter than the minimum can only be shown by the bench's timed scenarios.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  typedef enum logic [2:0] {
    PS_OFF,
    PS_RESET_WAIT,
    PS_STARTUP,
    PS_CALIBRATE,
    PS_READY
  } por_state_e;
endpackage

// File: rtl/por_dip_filter.sv
// Qualifies a low-supply indication: fires only after MIN_CYCLES consecutive edges.
module por_dip_filter #(
  parameter int MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic below_low,
  output logic dip_hit
);
  localparam int CW = $clog2(MIN_CYCLES + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYCLES);
  localparam logic [CW-1:0] FIRE_AT = CW'(MIN_CYCLES - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      dip_hit <= 1'b0;
    end else begin
      if (!below_low) run_cnt <= '0;
      else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
      dip_hit <= below_low && (run_cnt >= FIRE_AT);
    end
  end

  // R6: a qualified dip must be preceded by a low indication
  assert_dip_needs_low_R6: assert property (@(posedge clk) disable iff (rst)
    dip_hit |-> $past(below_low));
  // R6: the filter releases as soon as the indication clears
  assert_dip_release_R6: assert property (@(posedge clk) disable iff (rst)
    !below_low |=> !dip_hit);
endmodule

// File: rtl/por_phase_timer.sv
// Shared phase counter: loaded on phase entry, counts down to zero.
module por_phase_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec,
  output logic             expired
);
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && (cnt != '0)) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: without a load the count never grows
  assert_timer_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int RESET_CYCLES    = 25000,
  parameter int STARTUP_CYCLES  = 75000,
  parameter int BROWNOUT_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_valid,
  input  logic above_high,
  input  logic below_low,
  input  logic cal_done,
  output logic por_out,
  output logic clk_en,
  output logic cal_req,
  output logic mon_ready
);
  import por_seq_pkg::*;

  localparam int MAXC = (RESET_CYCLES > STARTUP_CYCLES) ? RESET_CYCLES : STARTUP_CYCLES;
  localparam int TW = $clog2(MAXC + 1);
  localparam logic [TW-1:0] RW_LOAD = TW'(RESET_CYCLES - 1);
  localparam logic [TW-1:0] SU_LOAD = TW'(STARTUP_CYCLES - 1);

  por_state_e state, nxt;
  logic dip_hit, expired, t_load, t_dec;
  logic [TW-1:0] t_val;

  por_dip_filter #(.MIN_CYCLES(BROWNOUT_CYCLES)) u_filter (
    .clk(clk), .rst(rst), .below_low(below_low), .dip_hit(dip_hit)
  );

  por_phase_timer #(.WIDTH(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .dec(t_dec), .expired(expired)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = RW_LOAD;
    t_dec  = 1'b0;
    if (!supply_valid) begin
      nxt = PS_OFF;
    end else begin
      unique case (state)
        PS_OFF: if (above_high) begin
          nxt = PS_RESET_WAIT;
          t_load = 1'b1;
        end
        PS_RESET_WAIT: begin
          if (dip_hit || !above_high) t_load = 1'b1;
          else if (expired) begin
            nxt = PS_STARTUP;
            t_load = 1'b1;
            t_val = SU_LOAD;
          end else t_dec = 1'b1;
        end
        PS_STARTUP: begin
          if (dip_hit) begin
            nxt = PS_RESET_WAIT;
            t_load = 1'b1;
          end else if (expired) nxt = PS_CALIBRATE;
          else t_dec = 1'b1;
        end
        PS_CALIBRATE: begin
          if (dip_hit) begin
            nxt = PS_RESET_WAIT;
            t_load = 1'b1;
          end else if (cal_done) nxt = PS_READY;
        end
        PS_READY: if (dip_hit) begin
          nxt = PS_RESET_WAIT;
          t_load = 1'b1;
        end
        default: nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_OFF;
      por_out   <= 1'b0;
      clk_en    <= 1'b0;
      cal_req   <= 1'b0;
      mon_ready <= 1'b0;
    end else begin
      state     <= nxt;
      por_out   <= (nxt == PS_STARTUP) || (nxt == PS_CALIBRATE) || (nxt == PS_READY);
      clk_en    <= (nxt == PS_CALIBRATE) || (nxt == PS_READY);
      cal_req   <= (nxt == PS_CALIBRATE);
      mon_ready <= (nxt == PS_READY);
    end
  end

  // R2: off phase with no upper-threshold indication keeps reset asserted
  assert_off_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (state == PS_OFF && !above_high) |=> !por_out);
  // R4: clock enable only after the reset has been released
  assert_clk_after_por_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> $past(por_out));
  // R5: readiness implies the rest of the chain is up and calibration is over
  assert_ready_chain_R5: assert property (@(posedge clk) disable iff (rst)
    mon_ready |-> (por_out && clk_en && !cal_req));
  assert_ready_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_ready) |-> $past(cal_done));
  // R7: a qualified dip drops the reset on the next edge
  assert_dip_resets_R7: assert property (@(posedge clk) disable iff (rst)
    (dip_hit && state != PS_OFF) |=> !por_out && !clk_en && !mon_ready);
  assert_por_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(por_out) |-> $past(dip_hit || !supply_valid));
  // R8: loss of validity clears every output
  assert_supply_loss_R8: assert property (@(posedge clk) disable iff (rst)
    !supply_valid |=> !por_out && !clk_en && !cal_req && !mon_ready);
endmodule

// File: tb/por_sequencer_bench.sv
module por_sequencer_bench;
  localparam int RC = 6;
  localparam int SC = 10;
  localparam int BC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_valid = 1'b0, above_high = 1'b0, below_low = 1'b0, cal_done = 1'b0;
  logic por_out, clk_en, cal_req, mon_ready;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  por_sequencer #(.RESET_CYCLES(RC), .STARTUP_CYCLES(SC), .BROWNOUT_CYCLES(BC)) u_por_sequencer (
    .clk(clk), .rst(rst), .supply_valid(supply_valid), .above_high(above_high),
    .below_low(below_low), .cal_done(cal_done), .por_out(por_out), .clk_en(clk_en),
    .cal_req(cal_req), .mon_ready(mon_ready)
  );

  // entry: req[19:16] inputs{valid,high,low,done}[15:12] edges[11:4] expect{por,clken,calreq,ready}[3:0]
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 4'b1000, 8'd3, 4'b0000},   // R2 valid but not above upper threshold
    {4'd2, 4'b1100, 8'd1, 4'b0000},   // R2 enter reset-wait
    {4'd3, 4'b1100, 8'd5, 4'b0000},   // R3 one edge before end of reset-wait
    {4'd3, 4'b1100, 8'd1, 4'b1000},   // R3 reset released
    {4'd4, 4'b1100, 8'd9, 4'b1000},   // R4 still in start-up
    {4'd4, 4'b1100, 8'd1, 4'b1110},   // R4 clock enabled, calibration requested
    {4'd5, 4'b1100, 8'd5, 4'b1110},   // R5 waiting for completion
    {4'd5, 4'b1101, 8'd1, 4'b1101},   // R5 ready
    {4'd6, 4'b1110, 8'd3, 4'b1101},   // R6 short dip
    {4'd6, 4'b1100, 8'd2, 4'b1101},   // R6 no effect afterwards
    {4'd7, 4'b1110, 8'd4, 4'b1101},   // R7 filter just qualified
    {4'd7, 4'b1110, 8'd1, 4'b0000},   // R7 reset forced
    {4'd9, 4'b1110, 8'd10, 4'b0000},  // R9 held while dip persists
    {4'd9, 4'b1100, 8'd6, 4'b0000},   // R9 one edge before release
    {4'd9, 4'b1100, 8'd1, 4'b1000},   // R9 released
    {4'd8, 4'b0100, 8'd1, 4'b0000},   // R8 supply invalid
    {4'd3, 4'b1100, 8'd4, 4'b0000},   // R3 re-enter and count
    {4'd3, 4'b1000, 8'd1, 4'b0000},   // R3 upper threshold lost: restart
    {4'd3, 4'b1100, 8'd5, 4'b0000},   // R3 restarted count not yet done
    {4'd3, 4'b1100, 8'd1, 4'b1000}    // R3 released after full restart
  };

  task automatic check(input int req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: outputs {por,clken,calreq,ready} = %b, expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {por_out, clk_en, cal_req, mon_ready};
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, outs(), 4'b0000);  // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check(1, outs(), 4'b0000);  // R1 first edge after reset

    for (int i = 0; i < NV; i++) begin
      {supply_valid, above_high, below_low, cal_done} = VEC[i][15:12];
      repeat (int'(VEC[i][11:4])) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][19:16]), outs(), VEC[i][3:0]);
    end

    // R2: upper threshold without validity stays off
    {supply_valid, above_high, below_low, cal_done} = 4'b0100;
    repeat (RC + 3) @(posedge clk);
    @(negedge clk);
    check(2, outs(), 4'b0000);

    // bring to ready, then a dip during calibration
    {supply_valid, above_high, below_low, cal_done} = 4'b1100;
    repeat (1 + RC + SC) @(posedge clk);
    @(negedge clk);
    check(4, outs(), 4'b1110);  // R4
    below_low = 1'b1;
    repeat (BC + 1) @(posedge clk);
    @(negedge clk);
    check(7, outs(), 4'b0000);  // R7 brown-out during calibration

    // R1: reset mid-sequence clears outputs
    below_low = 1'b0;
    repeat (RC + 3) @(posedge clk);
    @(negedge clk);
    check(3, outs(), 4'b1000);  // R3
    rst = 1'b1;
    @(negedge clk);
    check(1, outs(), 4'b0000);  // R1
    rst = 1'b0;
    report();
  end

  initial begin
    #(4 * 3000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end
endmodule